// File: doc/BRIEF.md
# Echo-Checked Row-Serial Print Sequencer

The block moves one print line between a word-oriented I/O channel and a line buffer of 24 words of 36 bits. The line is carried as twelve punch rows, each row a pair of words (left half and right half of a 72-column line). The rows come in this order: 9, 8, 7, 6, 5, 4, 3, 2, 1, 10, 11, 12. Buffer word k holds the k-th word in that order. When a line is complete, the block raises a one-cycle print strobe and presents the whole buffer. The printing mechanism and character conversion are outside the block.

A command carries a direction bit and a 2-bit device code. In write mode the channel supplies words and the line is printed once the record is full. In checked-read mode the block alternates two kinds of step. In one it takes words from the channel. In the other it reverses the channel direction and returns echo words built from rows already buffered, either single rows or the AND of two rows. This lets the channel side confirm what reached the buffer. All mechanical delays (motor start, latch point, print-wheel gap, timing-error recovery) are cycle-count parameters.

Top module: `rowprint_seq`

## Requirements
- R1: A command is accepted only when the low 2 bits of the device code are 1 (character line) or 2 (binary line). Codes 0 and 3 raise `cmd_reject` for one cycle and leave `busy` low. `print_binary` reports 1 for a binary-line command.
- R2: While `busy` is high, any new command is rejected. An accepted command clears all 24 buffer words, so a line printed before any word arrives is all zeros.
- R3: After acceptance, the first word is requested START_DLY cycles later if the motor was stopped. It is requested LATCH_DLY cycles later if the motor was running and idle, meaning a previous command ended within MOTOR_HOLD cycles.
- R4: A character write takes 24 words into buffer words 0 to 23 in arrival order. `eor_out` is high on the 24th word and on no earlier word.
- R5: A binary write ends its record on the 2nd word. After the gap, the 2-word line is printed, and the next word goes to buffer word 0.
- R6: In checked read, steps 0 to 17 load words 0 to 17. Steps 18 and 19 echo w2&w10 and w3&w11. Steps 20 and 21 load w18 and w19. Steps 22 and 23 echo w12&w2 and w13&w3. Steps 24 and 25 load w20 and w21. Steps 26 and 27 echo w0 and w1. Steps 28 and 29 load w22 and w23. Steps 30 to 45 echo w2 up to w17.
- R7: `ch_dir_out` is high on every echo step and low whenever the block requests an incoming word. The block never requests and offers a word in the same cycle.
- R8: In checked read, `eor_out` is high on the echo at step 45 only. After GAP_DLY cycles, step 46 prints the full line and the sequence wraps to step 0.
- R9: A print raises `print_strobe` for exactly one cycle. `print_line` holds buffer word k at bits [36k+35:36k]. The buffer is zero after the print.
- R10: A channel timing error during transfer raises `attn` and `eor_out` in the same cycle. `busy` then falls after TERR_BASE + TERR_UNIT*max(0, 12 - step/2) cycles.
- R11: A disconnect while a command is active prints the partial line, ends the command, and restarts the next command from step 0.
- R12: After reset the block is idle. `busy`, `ch_in_ready`, `ch_out_valid`, `ch_dir_out` and `print_strobe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command presented this cycle |
| cmd_write | input | 1 | 1 = write line, 0 = checked read |
| cmd_dev | input | 2 | Device code, low bits pick line type |
| cmd_accept | output | 1 | Command taken |
| cmd_reject | output | 1 | Command refused |
| busy | output | 1 | A command is active |
| ch_in_valid | input | 1 | Channel offers a word |
| ch_in_data | input | 36 | Incoming word |
| ch_in_ready | output | 1 | Block takes the offered word |
| ch_out_valid | output | 1 | Block offers an echo word |
| ch_out_data | output | 36 | Echo word |
| ch_out_ready | input | 1 | Channel takes the echo word |
| ch_dir_out | output | 1 | Channel direction is block to channel |
| ch_disc | input | 1 | Channel disconnect |
| ch_timing_err | input | 1 | Channel timing error |
| eor_out | output | 1 | End of record on this transfer |
| attn | output | 1 | Attention on timing error |
| print_strobe | output | 1 | Line ready to print |
| print_binary | output | 1 | Line is a binary image |
| print_line | output | 864 | Whole buffer, word k at bits 36k upward |

## Verification
A character write with distinct word values tells apart buffer ordering, the end-of-record position and the 24-word wrap. A binary write with the same bench shows the 2-word record length and the reuse of word 0. A checked read with words whose bit patterns overlap only partly separates every AND pair from its single-row neighbours, so a wrong row pairing or a wrong echo order shows in the data. Delay patterns compare a cold start with a warm one, check the recovery time of a timing error at a known step, and check a disconnect both before any word and after a few words.

// File: rtl/rps_pkg.sv
package rps_pkg;
    localparam int WORDS     = 24;
    localparam int POS_W     = 6;
    localparam int IDX_W     = 5;
    localparam int CHAR_LEN  = 24;
    localparam int BIN_LEN   = 2;
    localparam int RD_EORPOS = 45;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_XFER, ST_GAP, ST_PRINT, ST_TERR
    } state_e;

    typedef enum logic [1:0] {ACT_LOAD, ACT_ECHO, ACT_WRAP} act_e;

    typedef struct packed {
        act_e             act;
        logic [IDX_W-1:0] idx_a;
        logic [IDX_W-1:0] idx_b;
        logic             eor;
    } step_t;
endpackage

// File: rtl/rps_pos_decode.sv
module rps_pos_decode
    import rps_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  logic             wr_mode,
    input  logic             bin_mode,
    output step_t            step
);
    logic [POS_W-1:0] lim;

    always_comb begin
        step       = '0;
        step.act   = ACT_WRAP;
        lim        = bin_mode ? POS_W'(BIN_LEN) : POS_W'(CHAR_LEN);
        if (wr_mode) begin
            if (pos < lim) begin
                step.act   = ACT_LOAD;
                step.idx_a = IDX_W'(pos);
                step.eor   = (pos == lim - POS_W'(1));
            end
        end else if (pos <= 6'd17) begin
            step.act   = ACT_LOAD;
            step.idx_a = IDX_W'(pos);
        end else begin
            case (pos)
                6'd18: begin step.act = ACT_ECHO; step.idx_a = 5'd2;  step.idx_b = 5'd10; end
                6'd19: begin step.act = ACT_ECHO; step.idx_a = 5'd3;  step.idx_b = 5'd11; end
                6'd20: begin step.act = ACT_LOAD; step.idx_a = 5'd18; end
                6'd21: begin step.act = ACT_LOAD; step.idx_a = 5'd19; end
                6'd22: begin step.act = ACT_ECHO; step.idx_a = 5'd12; step.idx_b = 5'd2;  end
                6'd23: begin step.act = ACT_ECHO; step.idx_a = 5'd13; step.idx_b = 5'd3;  end
                6'd24: begin step.act = ACT_LOAD; step.idx_a = 5'd20; end
                6'd25: begin step.act = ACT_LOAD; step.idx_a = 5'd21; end
                6'd26: begin step.act = ACT_ECHO; step.idx_a = 5'd0;  step.idx_b = 5'd0;  end
                6'd27: begin step.act = ACT_ECHO; step.idx_a = 5'd1;  step.idx_b = 5'd1;  end
                6'd28: begin step.act = ACT_LOAD; step.idx_a = 5'd22; end
                6'd29: begin step.act = ACT_LOAD; step.idx_a = 5'd23; end
                default: begin
                    if (pos >= 6'd30 && pos <= POS_W'(RD_EORPOS)) begin
                        step.act   = ACT_ECHO;
                        step.idx_a = IDX_W'(pos - 6'd28);
                        step.idx_b = IDX_W'(pos - 6'd28);
                        step.eor   = (pos == POS_W'(RD_EORPOS));
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/rps_line_buf.sv
module rps_line_buf #(
    parameter int W  = 36,
    parameter int N  = 24,
    parameter int AW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [W-1:0]   wdata,
    input  logic [AW-1:0]  raddr_a,
    input  logic [AW-1:0]  raddr_b,
    output logic [W-1:0]   rdata_a,
    output logic [W-1:0]   rdata_b,
    output logic [N*W-1:0] line_flat
);
    logic [W-1:0] word_q [N];

    for (genvar k = 0; k < N; k++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[k] <= '0;
            else if (clr)
                word_q[k] <= '0;
            else if (we && waddr == AW'(k))
                word_q[k] <= wdata;
        end
        assign line_flat[k*W +: W] = word_q[k];
    end

    always_comb begin
        rdata_a = '0;
        rdata_b = '0;
        for (int k = 0; k < N; k++) begin
            if (raddr_a == AW'(k)) rdata_a = word_q[k];
            if (raddr_b == AW'(k)) rdata_b = word_q[k];
        end
    end
endmodule

// File: rtl/rps_delay.sv
module rps_delay #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rowprint_seq.sv
module rowprint_seq
    import rps_pkg::*;
#(
    parameter int WORD_W     = 36,
    parameter int START_DLY  = 330,
    parameter int LATCH_DLY  = 85,
    parameter int GAP_DLY    = 100,
    parameter int TERR_BASE  = 85,
    parameter int TERR_UNIT  = 13,
    parameter int MOTOR_HOLD = 330
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic                    cmd_write,
    input  logic [1:0]              cmd_dev,
    output logic                    cmd_accept,
    output logic                    cmd_reject,
    output logic                    busy,
    input  logic                    ch_in_valid,
    input  logic [WORD_W-1:0]       ch_in_data,
    output logic                    ch_in_ready,
    output logic                    ch_out_valid,
    output logic [WORD_W-1:0]       ch_out_data,
    input  logic                    ch_out_ready,
    output logic                    ch_dir_out,
    input  logic                    ch_disc,
    input  logic                    ch_timing_err,
    output logic                    eor_out,
    output logic                    attn,
    output logic                    print_strobe,
    output logic                    print_binary,
    output logic [WORDS*WORD_W-1:0] print_line
);
    localparam int MAX_DLY = START_DLY + LATCH_DLY + GAP_DLY + TERR_BASE + TERR_UNIT * 12;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);
    localparam int HOLD_W  = $clog2(MOTOR_HOLD + 1);

    typedef struct packed {
        state_e            st;
        logic [POS_W-1:0]  pos;
        logic              wr;
        logic              bin;
        logic              motor;
        logic [HOLD_W-1:0] hold;
        logic              then_idle;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    step_t             step;
    logic              buf_clr, buf_we;
    logic [WORD_W-1:0] rd_a, rd_b;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;
    int                rows_left;
    int                terr_cycles;

    rps_pos_decode u_dec (
        .pos      (ctl_q.pos),
        .wr_mode  (ctl_q.wr),
        .bin_mode (ctl_q.bin),
        .step     (step)
    );

    rps_line_buf #(.W(WORD_W), .N(WORDS), .AW(IDX_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .we        (buf_we),
        .waddr     (step.idx_a),
        .wdata     (ch_in_data),
        .raddr_a   (step.idx_a),
        .raddr_b   (step.idx_b),
        .rdata_a   (rd_a),
        .rdata_b   (rd_b),
        .line_flat (print_line)
    );

    rps_delay #(.CW(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // Recovery time after a timing error depends on how many rows remain.
    always_comb begin
        rows_left   = 12 - int'(ctl_q.pos[POS_W-1:1]);
        if (rows_left < 0) rows_left = 0;
        terr_cycles = TERR_BASE + TERR_UNIT * rows_left;
    end

    always_comb begin
        ctl_d        = ctl_q;
        cmd_accept   = 1'b0;
        cmd_reject   = 1'b0;
        ch_in_ready  = 1'b0;
        ch_out_valid = 1'b0;
        ch_dir_out   = 1'b0;
        eor_out      = 1'b0;
        attn         = 1'b0;
        print_strobe = 1'b0;
        buf_clr      = 1'b0;
        buf_we       = 1'b0;
        tmr_load     = 1'b0;
        tmr_val      = '0;

        case (ctl_q.st)
            ST_IDLE: begin
                if (ctl_q.motor) begin
                    if (ctl_q.hold == HOLD_W'(MOTOR_HOLD - 1)) begin
                        ctl_d.motor = 1'b0;
                        ctl_d.hold  = '0;
                    end else begin
                        ctl_d.hold = ctl_q.hold + HOLD_W'(1);
                    end
                end
                if (cmd_valid) begin
                    if (cmd_dev == 2'd1 || cmd_dev == 2'd2) begin
                        cmd_accept      = 1'b1;
                        buf_clr         = 1'b1;
                        tmr_load        = 1'b1;
                        tmr_val         = ctl_q.motor ? CNT_W'(LATCH_DLY - 1)
                                                      : CNT_W'(START_DLY - 1);
                        ctl_d.st        = ST_START;
                        ctl_d.pos       = '0;
                        ctl_d.wr        = cmd_write;
                        ctl_d.bin       = (cmd_dev == 2'd2);
                        ctl_d.hold      = '0;
                        ctl_d.then_idle = 1'b0;
                    end else begin
                        cmd_reject = 1'b1;
                    end
                end
            end

            ST_START, ST_GAP: begin
                if (ch_disc) begin
                    ctl_d.st        = ST_PRINT;
                    ctl_d.then_idle = 1'b1;
                end else if (tmr_done) begin
                    ctl_d.st    = ST_XFER;
                    ctl_d.motor = 1'b1;
                end
            end

            ST_XFER: begin
                if (ch_disc) begin
                    ctl_d.st        = ST_PRINT;
                    ctl_d.then_idle = 1'b1;
                end else if (ch_timing_err) begin
                    attn     = 1'b1;
                    eor_out  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(terr_cycles - 1);
                    ctl_d.st = ST_TERR;
                end else begin
                    case (step.act)
                        ACT_LOAD: begin
                            ch_in_ready = 1'b1;
                            if (ch_in_valid) begin
                                buf_we    = 1'b1;
                                ctl_d.pos = ctl_q.pos + POS_W'(1);
                                if (step.eor) begin
                                    eor_out  = 1'b1;
                                    tmr_load = 1'b1;
                                    tmr_val  = CNT_W'(GAP_DLY - 1);
                                    ctl_d.st = ST_GAP;
                                end
                            end
                        end
                        ACT_ECHO: begin
                            ch_out_valid = 1'b1;
                            ch_dir_out   = 1'b1;
                            if (ch_out_ready) begin
                                ctl_d.pos = ctl_q.pos + POS_W'(1);
                                if (step.eor) begin
                                    eor_out  = 1'b1;
                                    tmr_load = 1'b1;
                                    tmr_val  = CNT_W'(GAP_DLY - 1);
                                    ctl_d.st = ST_GAP;
                                end
                            end
                        end
                        default: begin
                            ctl_d.st        = ST_PRINT;
                            ctl_d.then_idle = 1'b0;
                        end
                    endcase
                end
            end

            ST_PRINT: begin
                print_strobe    = 1'b1;
                buf_clr         = 1'b1;
                ctl_d.pos       = '0;
                ctl_d.st        = ctl_q.then_idle ? ST_IDLE : ST_XFER;
                ctl_d.then_idle = 1'b0;
            end

            ST_TERR: begin
                if (tmr_done) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.pos = '0;
                end
            end

            default: ctl_d.st = ST_IDLE;
        endcase

        if (cmd_valid && ctl_q.st != ST_IDLE)
            cmd_reject = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q           <= '0;
            ctl_q.st        <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy         = (ctl_q.st != ST_IDLE);
    assign ch_out_data  = rd_a & rd_b;
    assign print_binary = ctl_q.bin;
endmodule

// File: rtl/rps_checker.sv
module rps_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_accept,
    input logic cmd_reject,
    input logic busy,
    input logic ch_in_ready,
    input logic ch_out_valid,
    input logic ch_dir_out,
    input logic eor_out,
    input logic attn,
    input logic print_strobe
);
    a_r7_echo_dir: assert property (@(posedge clk) disable iff (!rst_n)
        ch_out_valid |-> ch_dir_out);

    a_r7_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        !(ch_out_valid && ch_in_ready));

    a_r2_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |-> (cmd_reject && !cmd_accept));

    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> busy);

    a_r1_single_reply: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_accept, cmd_reject}));

    a_r9_strobe_once: assert property (@(posedge clk) disable iff (!rst_n)
        print_strobe |=> !print_strobe);

    a_r10_attn_eor: assert property (@(posedge clk) disable iff (!rst_n)
        attn |-> eor_out);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ch_in_ready && !ch_out_valid && !print_strobe));
endmodule

bind rowprint_seq rps_checker u_rps_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_accept   (cmd_accept),
    .cmd_reject   (cmd_reject),
    .busy         (busy),
    .ch_in_ready  (ch_in_ready),
    .ch_out_valid (ch_out_valid),
    .ch_dir_out   (ch_dir_out),
    .eor_out      (eor_out),
    .attn         (attn),
    .print_strobe (print_strobe)
);

// File: tb/rowprint_seq_tb_top.sv
module rowprint_seq_tb_top;
    localparam int W  = 36;
    localparam int N  = 24;
    localparam int START_DLY = 330;
    localparam int LATCH_DLY = 85;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [1:0] cmd_dev = 2'd0;
    logic cmd_accept, cmd_reject, busy;
    logic ch_in_valid = 1'b0;
    logic [W-1:0] ch_in_data = '0;
    logic ch_in_ready, ch_out_valid, ch_dir_out;
    logic [W-1:0] ch_out_data;
    logic ch_out_ready = 1'b1;
    logic ch_disc = 1'b0, ch_timing_err = 1'b0;
    logic eor_out, attn, print_strobe, print_binary;
    logic [N*W-1:0] print_line;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [W-1:0]   echo_q[$];
    logic           echo_eor_q[$];
    logic [N*W-1:0] line_q[$];
    logic           bin_q[$];

    always #5 clk = ~clk;

    rowprint_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_dev(cmd_dev),
        .cmd_accept(cmd_accept), .cmd_reject(cmd_reject), .busy(busy),
        .ch_in_valid(ch_in_valid), .ch_in_data(ch_in_data), .ch_in_ready(ch_in_ready),
        .ch_out_valid(ch_out_valid), .ch_out_data(ch_out_data), .ch_out_ready(ch_out_ready),
        .ch_dir_out(ch_dir_out), .ch_disc(ch_disc), .ch_timing_err(ch_timing_err),
        .eor_out(eor_out), .attn(attn),
        .print_strobe(print_strobe), .print_binary(print_binary), .print_line(print_line)
    );

    task automatic chk(input bit ok, input string tag, input string txt);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, txt);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Monitor: compares echoes and printed lines against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ch_out_valid && ch_out_ready) begin
                if (echo_q.size() == 0) begin
                    chk(0, "R6", $sformatf("unexpected echo %h, expected none", ch_out_data));
                end else begin
                    logic [W-1:0] e;
                    logic ee;
                    e  = echo_q.pop_front();
                    ee = echo_eor_q.pop_front();
                    chk(ch_out_data === e, "R6", $sformatf("echo %h expected %h", ch_out_data, e));
                    chk(eor_out === ee, "R8", $sformatf("echo eor %b expected %b", eor_out, ee));
                    chk(ch_dir_out === 1'b1, "R7", $sformatf("dir %b expected 1", ch_dir_out));
                end
            end
            if (print_strobe) begin
                if (line_q.size() == 0) begin
                    chk(0, "R9", "unexpected print strobe, expected none");
                end else begin
                    logic [N*W-1:0] l;
                    logic b;
                    l = line_q.pop_front();
                    b = bin_q.pop_front();
                    chk(print_line === l, "R9", $sformatf("line %h expected %h", print_line, l));
                    chk(print_binary === b, "R1", $sformatf("binary %b expected %b", print_binary, b));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WATCHDOG", "run hung, expected completion");
        finish_run();
    end

    task automatic issue_cmd(input bit wr, input logic [1:0] dev, input bit exp_ok, input string tag);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_write = wr; cmd_dev = dev;
        @(negedge clk);
        chk(cmd_accept === exp_ok && cmd_reject === !exp_ok, tag,
            $sformatf("accept/reject %b%b expected %b%b", cmd_accept, cmd_reject, exp_ok, !exp_ok));
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic send_word(input logic [W-1:0] d, input bit exp_eor, input string tag);
        @(posedge clk); #1;
        ch_in_valid = 1'b1; ch_in_data = d;
        @(negedge clk);
        while (!ch_in_ready) @(negedge clk);
        chk(eor_out === exp_eor, tag, $sformatf("eor %b expected %b", eor_out, exp_eor));
        chk(ch_dir_out === 1'b0, "R7", $sformatf("dir %b expected 0 on load", ch_dir_out));
        @(posedge clk); #1;
        ch_in_valid = 1'b0;
    endtask

    task automatic pulse_disc();
        @(posedge clk); #1; ch_disc = 1'b1;
        @(posedge clk); #1; ch_disc = 1'b0;
    endtask

    task automatic count_ready(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (ch_in_ready) break;
            n++;
        end
    endtask

    task automatic drain();
        while (echo_q.size() != 0 || line_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [W-1:0] pat(input int k, input int salt);
        return W'(36'h9_1234_5670) ^ (W'(k + 1) * W'(36'h0_0F0F_0F0F)) ^ W'(salt) ^ (W'(1) << (k % W));
    endfunction

    initial begin
        int n;
        logic [W-1:0] w [N];
        logic [N*W-1:0] line;

        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!busy && !ch_in_ready && !ch_out_valid && !ch_dir_out && !print_strobe, "R12",
            $sformatf("reset outputs %b%b%b%b%b expected 00000", busy, ch_in_ready, ch_out_valid, ch_dir_out, print_strobe));
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1: rejected device codes
        issue_cmd(1'b1, 2'd0, 1'b0, "R1");
        issue_cmd(1'b1, 2'd3, 1'b0, "R1");
        @(negedge clk);
        chk(busy === 1'b0, "R1", $sformatf("busy %b expected 0 after rejects", busy));

        // R3 cold start, R4 character write, R2 busy rejection
        issue_cmd(1'b1, 2'd1, 1'b1, "R1");
        count_ready(n);
        chk(n >= START_DLY - 1 && n <= START_DLY + 1, "R3", $sformatf("cold delay %0d expected %0d", n, START_DLY));
        line = '0;
        for (int k = 0; k < N; k++) begin
            w[k] = pat(k, 11);
            line[k*W +: W] = w[k];
        end
        line_q.push_back(line); bin_q.push_back(1'b0);
        for (int k = 0; k < N; k++) begin
            send_word(w[k], k == N - 1, "R4");
            if (k == 4) issue_cmd(1'b1, 2'd1, 1'b0, "R2");
        end
        drain();
        line = '0;
        for (int k = 0; k < 3; k++) line[k*W +: W] = pat(k, 77);
        line_q.push_back(line); bin_q.push_back(1'b0);
        for (int k = 0; k < 3; k++) send_word(pat(k, 77), 1'b0, "R4");
        pulse_disc();
        drain();
        chk(busy === 1'b0, "R11", $sformatf("busy %b expected 0 after disconnect", busy));

        // R3 warm start, R10 timing error at step 4
        issue_cmd(1'b1, 2'd1, 1'b1, "R3");
        count_ready(n);
        chk(n >= LATCH_DLY - 1 && n <= LATCH_DLY + 1, "R3", $sformatf("warm delay %0d expected %0d", n, LATCH_DLY));
        for (int k = 0; k < 4; k++) send_word(pat(k, 5), 1'b0, "R4");
        @(posedge clk); #1; ch_timing_err = 1'b1;
        @(negedge clk);
        chk(attn === 1'b1 && eor_out === 1'b1, "R10", $sformatf("attn/eor %b%b expected 11", attn, eor_out));
        @(posedge clk); #1; ch_timing_err = 1'b0;
        n = 0;
        forever begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
        chk(n >= 214 && n <= 216, "R10", $sformatf("recovery %0d expected 215", n));

        // R2 buffer cleared on start, R11 disconnect before any word
        issue_cmd(1'b1, 2'd1, 1'b1, "R2");
        count_ready(n);
        line_q.push_back('0); bin_q.push_back(1'b0);
        pulse_disc();
        drain();

        // R5 binary write
        issue_cmd(1'b1, 2'd2, 1'b1, "R1");
        count_ready(n);
        line = '0;
        line[0 +: W] = pat(0, 3);
        line[W +: W] = pat(1, 3);
        line_q.push_back(line); bin_q.push_back(1'b1);
        send_word(pat(0, 3), 1'b0, "R5");
        send_word(pat(1, 3), 1'b1, "R5");
        drain();
        line = '0;
        line[0 +: W] = pat(2, 3);
        line_q.push_back(line); bin_q.push_back(1'b1);
        send_word(pat(2, 3), 1'b0, "R5");
        pulse_disc();
        drain();

        // R6, R7, R8 checked read
        issue_cmd(1'b0, 2'd1, 1'b1, "R6");
        count_ready(n);
        line = '0;
        for (int k = 0; k < N; k++) begin
            w[k] = pat(k, 901) | W'(36'h0_0000_3C00);
            line[k*W +: W] = w[k];
        end
        echo_q.push_back(w[2] & w[10]);  echo_eor_q.push_back(1'b0);
        echo_q.push_back(w[3] & w[11]);  echo_eor_q.push_back(1'b0);
        echo_q.push_back(w[12] & w[2]);  echo_eor_q.push_back(1'b0);
        echo_q.push_back(w[13] & w[3]);  echo_eor_q.push_back(1'b0);
        echo_q.push_back(w[0]);          echo_eor_q.push_back(1'b0);
        echo_q.push_back(w[1]);          echo_eor_q.push_back(1'b0);
        for (int k = 2; k <= 17; k++) begin
            echo_q.push_back(w[k]);
            echo_eor_q.push_back(k == 17);
        end
        line_q.push_back(line); bin_q.push_back(1'b0);
        for (int k = 0; k < N; k++) send_word(w[k], 1'b0, "R6");
        drain();
        line = '0;
        line[0 +: W] = pat(40, 1);
        line_q.push_back(line); bin_q.push_back(1'b0);
        send_word(pat(40, 1), 1'b0, "R8");
        pulse_disc();
        drain();
        chk(echo_q.size() == 0 && line_q.size() == 0, "R9",
            $sformatf("leftover %0d/%0d expected 0/0", echo_q.size(), line_q.size()));

        finish_run();
    end
endmodule